// File: doc/BRIEF.md
# I2C Transmit Queue with DMA Burst Handshake

This block holds the bytes an I2C master is about to shift out. A DMA engine fills it and the serial shift engine empties it. A transfer-active input gates the block. While a transfer is active, the block compares its fill level against a programmable low-water mark. When the level has fallen to the mark or below, it asks the DMA engine for a burst. Each acknowledged request opens a window for a fixed number of write beats. The request stays down until the last beat of that window has arrived, and only then is it evaluated again.

If the shift engine asks for a byte while the queue is empty during a transfer, the block does not end the transfer. It raises a stall output so that the shift engine holds the serial clock low until data arrives. Sticky flags record dropped writes and starved reads.

A typical setting pairs a depth of 64 with a mark of 16 and a burst of 48. Each burst then exactly fills the free space, and a 240-byte block moves in five bursts.

Top module: `i2c_txq_dma`

## Requirements
- R1: `dma_req` is high exactly when `xfer_active` is high, no burst is open, and `level` is less than or equal to the latched mark (unsigned compare, 7 bits).
- R2: A cycle with `dma_req` and `dma_ack` both high opens a burst of L write beats, where L is the latched burst length. A length of zero makes the acknowledge a no-op. `dma_req` stays low from the cycle after the acknowledge until the cycle after the L-th `dma_wr` beat.
- R3: A beat inside a burst that arrives while the queue is full is discarded, leaves `level` unchanged, and sets `ovf_flag`. The flag stays set until reset.
- R4: A `dma_wr` beat outside an open burst is ignored. It changes neither `level` nor `ovf_flag`.
- R5: `tx_valid` is high whenever the queue holds data, and `tx_data` is the oldest byte. A `tx_pop` while data is present removes that byte, so bytes leave in arrival order.
- R6: A `tx_pop` on an empty queue while `xfer_active` is high sets `scl_stall` and the sticky `udf_flag` on the next cycle. With `xfer_active` low, the same pop has no effect.
- R7: `scl_stall` stays high while the queue remains empty and the transfer is active. It drops on the cycle after the queue becomes non-empty.
- R8: `cfg_wmark` and `cfg_burst` are sampled only while no burst is open. A change made during a burst neither alters that burst's length nor takes effect before the burst has closed.
- R9: After reset, `empty` is 1, `full` is 0, `level` is 0, and all flags and the stall are 0. `full` is high exactly when `level` equals the depth.
- R10: With a mark of 16, a burst length of 48 and a depth of 64, a 240-byte block passes through in exactly five bursts with no loss and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wmark | input | 7 | Low-water mark for requests |
| cfg_burst | input | 7 | Beats per DMA burst |
| xfer_active | input | 1 | A serial transfer is in progress |
| dma_req | output | 1 | Burst request to the DMA engine |
| dma_ack | input | 1 | DMA engine accepts the request |
| dma_wr | input | 1 | Write beat strobe |
| dma_wdata | input | 8 | Write beat data |
| tx_pop | input | 1 | Shift engine takes a byte |
| tx_valid | output | 1 | A byte is available |
| tx_data | output | 8 | Oldest byte in the queue |
| scl_stall | output | 1 | Hold the serial clock low |
| level | output | 7 | Number of bytes held |
| full | output | 1 | Queue is full |
| empty | output | 1 | Queue is empty |
| ovf_flag | output | 1 | Sticky: a write was dropped |
| udf_flag | output | 1 | Sticky: a pop found the queue empty |

## Verification
The bench builds the block with its defaults: depth 64, 8-bit data and 7-bit configuration fields. At this depth the example configuration of mark 16 and burst 48 can be run end to end, including the five-burst transfer of 240 bytes. It also makes it possible to fill the queue to its limit with a 60-beat burst that drops its last twelve beats. Small settings such as a burst of 1 or 4 are used to observe the stall release and the deferred sampling of the configuration.

// File: rtl/i2c_txq_pkg.sv
`timescale 1ns/1ps
package i2c_txq_pkg;
   typedef enum logic [0:0] {
      BQ_IDLE  = 1'b0,
      BQ_BURST = 1'b1
   } burst_st_e;
endpackage

// File: rtl/txq_store.sv
`timescale 1ns/1ps
module txq_store #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata,
   output logic [CNT_W-1:0] level,
   output logic             full,
   output logic             empty
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push) wp <= wp + AW'(1);
         if (pop)  rp <= rp + AW'(1);
         case ({push, pop})
            2'b10:   level <= level + CNT_W'(1);
            2'b01:   level <= level - CNT_W'(1);
            default: level <= level;
         endcase
      end
   end

   assign rdata = mem[rp];
   assign full  = (level == CNT_W'(DEPTH));
   assign empty = (level == '0);
endmodule

// File: rtl/txq_burst_ctl.sv
`timescale 1ns/1ps
module txq_burst_ctl
   import i2c_txq_pkg::*;
#(
   parameter int LVL_W = 7,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] cfg_wmark,
   input  logic [LVL_W-1:0] cfg_burst,
   input  logic             xfer_active,
   input  logic [CNT_W-1:0] level,
   input  logic             dma_ack,
   input  logic             dma_wr,
   output logic             dma_req,
   output logic             in_burst,
   output logic [LVL_W-1:0] wm_eff
);
   burst_st_e        st;
   logic [LVL_W-1:0] bl_q, left;
   logic [LVL_W-1:0] lvl_x;

   assign lvl_x    = LVL_W'(level);
   assign in_burst = (st == BQ_BURST);
   assign dma_req  = (st == BQ_IDLE) && xfer_active && (lvl_x <= wm_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= BQ_IDLE;
         left   <= '0;
         wm_eff <= '0;
         bl_q   <= '0;
      end else begin
         case (st)
            BQ_IDLE: begin
               wm_eff <= cfg_wmark;
               bl_q   <= cfg_burst;
               if (dma_req && dma_ack && (bl_q != '0)) begin
                  st   <= BQ_BURST;
                  left <= bl_q;
               end
            end
            default: begin
               if (dma_wr) begin
                  left <= left - LVL_W'(1);
                  if (left == LVL_W'(1)) st <= BQ_IDLE;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/txq_underrun.sv
`timescale 1ns/1ps
module txq_underrun (
   input  logic clk,
   input  logic rst_n,
   input  logic pop,
   input  logic empty,
   input  logic xfer_active,
   output logic stall,
   output logic udf_flag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall    <= 1'b0;
         udf_flag <= 1'b0;
      end else if (pop && empty && xfer_active) begin
         stall    <= 1'b1;
         udf_flag <= 1'b1;
      end else if (!empty || !xfer_active) begin
         stall    <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_txq_dma.sv
`timescale 1ns/1ps
module i2c_txq_dma #(
   parameter int DEPTH = 64,
   parameter int DW    = 8,
   parameter int LVL_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] cfg_wmark,
   input  logic [LVL_W-1:0] cfg_burst,
   input  logic             xfer_active,
   output logic             dma_req,
   input  logic             dma_ack,
   input  logic             dma_wr,
   input  logic [DW-1:0]    dma_wdata,
   input  logic             tx_pop,
   output logic             tx_valid,
   output logic [DW-1:0]    tx_data,
   output logic             scl_stall,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             ovf_flag,
   output logic             udf_flag
);
   localparam int CNT_W = $clog2(DEPTH+1);

   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (LVL_W < CNT_W) begin : g_bad_lvl
         $error("LVL_W too narrow to express a mark up to DEPTH");
      end
      if (DW < 1) begin : g_bad_dw
         $error("DW must be positive");
      end
   endgenerate

   logic             in_burst;
   logic [LVL_W-1:0] wm_eff;
   logic             push_ok, pop_ok;

   assign push_ok  = dma_wr && in_burst && !full;
   assign pop_ok   = tx_pop && !empty;
   assign tx_valid = !empty;

   txq_store #(.DEPTH(DEPTH), .DW(DW), .CNT_W(CNT_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push_ok),
      .pop   (pop_ok),
      .wdata (dma_wdata),
      .rdata (tx_data),
      .level (level),
      .full  (full),
      .empty (empty)
   );

   txq_burst_ctl #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wmark   (cfg_wmark),
      .cfg_burst   (cfg_burst),
      .xfer_active (xfer_active),
      .level       (level),
      .dma_ack     (dma_ack),
      .dma_wr      (dma_wr),
      .dma_req     (dma_req),
      .in_burst    (in_burst),
      .wm_eff      (wm_eff)
   );

   txq_underrun u_udr (
      .clk         (clk),
      .rst_n       (rst_n),
      .pop         (tx_pop),
      .empty       (empty),
      .xfer_active (xfer_active),
      .stall       (scl_stall),
      .udf_flag    (udf_flag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                          ovf_flag <= 1'b0;
      else if (dma_wr && in_burst && full) ovf_flag <= 1'b1;
   end
endmodule

// File: rtl/txq_dma_chk.sv
`timescale 1ns/1ps
module txq_dma_chk #(
   parameter int LVL_W = 7,
   parameter int CNT_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             xfer_active,
   input logic             dma_req,
   input logic             dma_wr,
   input logic             tx_pop,
   input logic             empty,
   input logic             full,
   input logic [CNT_W-1:0] level,
   input logic             scl_stall,
   input logic             ovf_flag,
   input logic             udf_flag,
   input logic             in_burst,
   input logic [LVL_W-1:0] wm_eff
);
   a_r1_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
      dma_req |-> (xfer_active && (LVL_W'(level) <= wm_eff)));

   a_r2_quiet_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
      in_burst |-> !dma_req);

   a_r3_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr && in_burst && full) |=> ovf_flag);

   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag |=> ovf_flag);

   a_r4_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr && !in_burst && !tx_pop) |=> $stable(level));

   a_r5_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && !empty && !(dma_wr && in_burst)) |=> (level == $past(level) - CNT_W'(1)));

   a_r6_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && empty && xfer_active) |=> (scl_stall && udf_flag));

   a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
      !empty |=> !scl_stall);

   a_r9_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

bind i2c_txq_dma txq_dma_chk #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xfer_active (xfer_active),
   .dma_req     (dma_req),
   .dma_wr      (dma_wr),
   .tx_pop      (tx_pop),
   .empty       (empty),
   .full        (full),
   .level       (level),
   .scl_stall   (scl_stall),
   .ovf_flag    (ovf_flag),
   .udf_flag    (udf_flag),
   .in_burst    (in_burst),
   .wm_eff      (wm_eff)
);

// File: tb/i2c_txq_dma_test.sv
`timescale 1ns/1ps
module i2c_txq_dma_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [6:0] cfg_wmark, cfg_burst;
   logic       xfer_active, dma_req, dma_ack, dma_wr;
   logic [7:0] dma_wdata;
   logic       tx_pop, tx_valid;
   logic [7:0] tx_data;
   logic       scl_stall;
   logic [6:0] level;
   logic       full, empty, ovf_flag, udf_flag;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] q[$];

   always #10 clk = ~clk;

   i2c_txq_dma uut (
      .clk(clk), .rst_n(rst_n), .cfg_wmark(cfg_wmark), .cfg_burst(cfg_burst),
      .xfer_active(xfer_active), .dma_req(dma_req), .dma_ack(dma_ack),
      .dma_wr(dma_wr), .dma_wdata(dma_wdata), .tx_pop(tx_pop),
      .tx_valid(tx_valid), .tx_data(tx_data), .scl_stall(scl_stall),
      .level(level), .full(full), .empty(empty),
      .ovf_flag(ovf_flag), .udf_flag(udf_flag)
   );

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // acknowledge at the current negedge, then n beats; model mirrors accepted beats
   task automatic dma_burst(input int n, input int base);
      #1 chk("R2 request before ack", int'(dma_req), 1);
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      for (int i = 0; i < n; i++) begin
         dma_wr = 1'b1;
         dma_wdata = 8'(base + i);
         #1 chk("R2 request low in burst", int'(dma_req), 0);
         if (q.size() < 64) q.push_back(8'(base + i));
         @(negedge clk);
      end
      dma_wr = 1'b0;
   endtask

   task automatic pop_n(input int n);
      for (int i = 0; i < n; i++) begin
         tx_pop = 1'b1;
         #1;
         chk("R5 valid", int'(tx_valid), 1);
         chk("R5 order", int'(tx_data), int'(q[0]));
         void'(q.pop_front());
         @(negedge clk);
      end
      tx_pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R9 empty", int'(empty), 1);
      chk("R9 full", int'(full), 0);
      chk("R9 level", int'(level), 0);
      chk("R1 req idle", int'(dma_req), 0);
      chk("R9 stall", int'(scl_stall), 0);
      chk("R9 ovf", int'(ovf_flag), 0);
      chk("R9 udf", int'(udf_flag), 0);
      chk("R5 valid empty", int'(tx_valid), 0);
   endtask

   task automatic t_idle_pop();
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
      chk("R6 idle pop stall", int'(scl_stall), 0);
      chk("R6 idle pop udf", int'(udf_flag), 0);
   endtask

   task automatic t_gate();
      cfg_wmark = 7'd16; cfg_burst = 7'd48;
      @(negedge clk);
      #1 chk("R1 gated by idle", int'(dma_req), 0);
      xfer_active = 1'b1;
      #1 chk("R1 active and low", int'(dma_req), 1);
   endtask

   task automatic t_fill();
      dma_burst(48, 0);
      chk("R2 level after burst", int'(level), 48);
      chk("R1 above mark", int'(dma_req), 0);
      dma_wr = 1'b1; dma_wdata = 8'hEE;
      @(negedge clk);
      dma_wr = 1'b0;
      chk("R4 stray write level", int'(level), 48);
      chk("R4 stray write ovf", int'(ovf_flag), 0);
   endtask

   task automatic t_mark_edge();
      pop_n(31);
      chk("R1 level 17", int'(level), 17);
      chk("R1 no req at 17", int'(dma_req), 0);
      pop_n(1);
      chk("R1 req at 16", int'(dma_req), 1);
   endtask

   task automatic t_overflow();
      cfg_burst = 7'd60;
      @(negedge clk);
      dma_burst(60, 100);
      chk("R3 level capped", int'(level), 64);
      chk("R9 full", int'(full), 1);
      chk("R3 ovf set", int'(ovf_flag), 1);
      chk("R1 no req when full", int'(dma_req), 0);
      cfg_burst = 7'd48;
      @(negedge clk);
      chk("R3 ovf sticky", int'(ovf_flag), 1);
   endtask

   task automatic t_drain();
      pop_n(64);
      chk("R9 empty after drain", int'(empty), 1);
      chk("R5 valid low", int'(tx_valid), 0);
   endtask

   task automatic t_underflow();
      tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
      chk("R6 stall set", int'(scl_stall), 1);
      chk("R6 udf set", int'(udf_flag), 1);
      cfg_burst = 7'd1;
      @(negedge clk);
      chk("R7 stall held", int'(scl_stall), 1);
      dma_burst(1, 200);
      chk("R7 level 1", int'(level), 1);
      chk("R7 stall still high", int'(scl_stall), 1);
      @(negedge clk);
      chk("R7 stall released", int'(scl_stall), 0);
      chk("R6 udf sticky", int'(udf_flag), 1);
      pop_n(1);
   endtask

   task automatic t_cfg_mid();
      cfg_wmark = 7'd3; cfg_burst = 7'd4;
      @(negedge clk);
      #1 chk("R8 req before burst", int'(dma_req), 1);
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (i == 2) begin cfg_burst = 7'd10; cfg_wmark = 7'd4; end
         dma_wr = 1'b1; dma_wdata = 8'(50 + i);
         q.push_back(8'(50 + i));
         @(negedge clk);
      end
      dma_wdata = 8'd99;
      #1 chk("R8 old mark still used", int'(dma_req), 0);
      @(negedge clk);
      dma_wr = 1'b0;
      chk("R8 burst kept length", int'(level), 4);
      chk("R8 new mark after burst", int'(dma_req), 1);
      pop_n(4);
   endtask

   task automatic t_block();
      int sent = 0;
      int bursts = 0;
      int popped = 0;
      cfg_wmark = 7'd16; cfg_burst = 7'd48;
      @(negedge clk);
      while (sent < 240) begin
         for (int k = 0; k < 4 && !dma_req; k++) @(negedge clk);
         dma_burst(48, sent);
         sent += 48;
         bursts++;
         if (sent < 240) begin
            popped += q.size() - 16;
            pop_n(q.size() - 16);
         end else begin
            popped += q.size();
            pop_n(q.size());
         end
      end
      chk("R10 burst count", bursts, 5);
      chk("R10 bytes out", popped, 240);
      chk("R10 empty at end", int'(empty), 1);
      chk("R10 no stall", int'(scl_stall), 0);
   endtask

   initial begin
      #3000000;
      n_bad++;
      $display("FAIL watchdog R10: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; cfg_wmark = '0; cfg_burst = '0; xfer_active = 1'b0;
      dma_ack = 1'b0; dma_wr = 1'b0; dma_wdata = '0; tx_pop = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_pop();
      t_gate();
      t_fill();
      t_mark_edge();
      t_overflow();
      t_drain();
      t_underflow();
      t_cfg_mid();
      t_block();
      finish_run();
   end
endmodule